// File: doc/BRIEF.md
# Aging-Counter Victim Selector

This block ranks a fixed set of resident page frames by how long each has gone unused and names the frame to evict. Every frame keeps a use flag and a saturating idle counter. An access strobe with a frame index marks that frame as used. A periodic tick closes an interval. At each tick, every frame that was used has its counter cleared. Every frame that was not used has its counter raised by one. All use flags then drop.

When a victim is requested, the block searches the counters for the largest value and returns that frame's index together with its count. The result is registered. Filling a frame with a new page restarts that frame's history. The surrounding system owns the page tables, the page transfer and the tick period. This block only keeps the ranking and answers the selection query.

Top module: `age_victim_sel`

## Requirements
- R1: After reset every counter is 0, every use flag is 0 and `vic_vld` is 0, so a first request returns index 0 with age 0.
- R2: An access strobe (`acc_vld` high, frame number on `acc_idx`) marks that frame as used. At the next tick, a used frame's counter becomes 0.
- R3: At a tick, the counter of a frame that was not used rises by one. A counter that is already at 2^CNT_W-1 stays there and does not wrap.
- R4: After a tick, every use flag is 0, so a frame that is not accessed again ages on the following tick.
- R5: An access strobe in the same cycle as a tick belongs to the interval that this tick closes. The frame's counter becomes 0 at that tick, and its use flag is not left set afterwards.
- R6: The selected victim is a frame whose counter holds the largest value among all frames. `vic_age` carries that value.
- R7: When several frames share the largest count, the one with the lowest index is selected.
- R8: `vic_vld` is high in exactly the cycle after a cycle with `vic_req` high, and low otherwise. `vic_idx`/`vic_age` reflect the counters as they stood before the clock edge that captured the request, so a tick in the request cycle does not change that answer.
- R9: A fill strobe (`fill_vld`, `fill_idx`) sets that frame's counter to 0 and its use flag to 1. A fill overrides a tick or an access in the same cycle, so the filled frame also reads 0 after the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Access strobe |
| acc_idx | input | IDX_W | Frame touched by the access |
| fill_vld | input | 1 | Fill strobe (new page loaded) |
| fill_idx | input | IDX_W | Frame being filled |
| tick | input | 1 | End of an aging interval |
| vic_req | input | 1 | Victim request |
| vic_vld | output | 1 | Victim result valid, one cycle after request |
| vic_idx | output | IDX_W | Selected frame |
| vic_age | output | CNT_W | Counter value of the selected frame |

## Verification
A strobe or tick driven in one cycle changes a counter or use flag at the next rising edge. That state is only visible through a later victim request. The result of that request appears on `vic_vld`, `vic_idx` and `vic_age` one edge after the request is captured. The bench therefore drives every input at a falling edge, lets one rising edge pass, and samples the result at the following falling edge. It then checks that `vic_vld` has dropped one cycle later. Each scenario arranges the counters so that the frame whose behaviour is under test decides which index wins, which exposes its hidden counter at the ports.

// File: rtl/age_pkg.sv
package age_pkg;

  // Action a frame cell takes in a given cycle, in priority order.
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_MARK = 2'd1,
    OP_TICK = 2'd2,
    OP_LOAD = 2'd3
  } cell_op_e;

endpackage

// File: rtl/age_strobe_dec.sv
module age_strobe_dec #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     hit
);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      hit[i] = en && (idx == IDX_W'(i));
    end
  end

endmodule

// File: rtl/age_frame_cell.sv
module age_frame_cell
  import age_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_hit,
  input  logic             fill_hit,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             used
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  cell_op_e op;

  always_comb begin
    if (fill_hit)     op = OP_LOAD;
    else if (tick)    op = OP_TICK;
    else if (acc_hit) op = OP_MARK;
    else              op = OP_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      used <= 1'b0;
    end else begin
      case (op)
        OP_LOAD: begin
          cnt  <= '0;
          used <= 1'b1;
        end
        OP_TICK: begin
          if (used || acc_hit) cnt <= '0;
          else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          used <= 1'b0;
        end
        OP_MARK: used <= 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/age_argmax.sv
module age_argmax #(
  parameter int N     = 8,
  parameter int CNT_W = 4,
  parameter int IDX_W = 3
) (
  input  logic [CNT_W-1:0] cnt [N],
  output logic [IDX_W-1:0] best_idx,
  output logic [CNT_W-1:0] best_cnt
);

  // Strict greater-than keeps the earliest index on ties.
  always_comb begin
    best_idx = '0;
    best_cnt = cnt[0];
    for (int i = 1; i < N; i++) begin
      if (cnt[i] > best_cnt) begin
        best_cnt = cnt[i];
        best_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/age_victim_sel.sv
module age_victim_sel #(
  parameter int NUM_FRAMES = 8,
  parameter int CNT_W      = 4,
  localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_vld,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             fill_vld,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             tick,
  input  logic             vic_req,
  output logic             vic_vld,
  output logic [IDX_W-1:0] vic_idx,
  output logic [CNT_W-1:0] vic_age
);

  logic [NUM_FRAMES-1:0] acc_hit;
  logic [NUM_FRAMES-1:0] fill_hit;
  logic [NUM_FRAMES-1:0] used_vec;
  logic [CNT_W-1:0]      cnt_arr [NUM_FRAMES];
  logic [IDX_W-1:0]      best_idx;
  logic [CNT_W-1:0]      best_cnt;

  age_strobe_dec #(.N(NUM_FRAMES), .IDX_W(IDX_W)) u_acc_dec (
    .en (acc_vld),
    .idx(acc_idx),
    .hit(acc_hit)
  );

  age_strobe_dec #(.N(NUM_FRAMES), .IDX_W(IDX_W)) u_fill_dec (
    .en (fill_vld),
    .idx(fill_idx),
    .hit(fill_hit)
  );

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cell
    age_frame_cell #(.CNT_W(CNT_W)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .acc_hit (acc_hit[g]),
      .fill_hit(fill_hit[g]),
      .tick    (tick),
      .cnt     (cnt_arr[g]),
      .used    (used_vec[g])
    );
  end

  age_argmax #(.N(NUM_FRAMES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_argmax (
    .cnt     (cnt_arr),
    .best_idx(best_idx),
    .best_cnt(best_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vic_vld <= 1'b0;
      vic_idx <= '0;
      vic_age <= '0;
    end else begin
      vic_vld <= vic_req;
      if (vic_req) begin
        vic_idx <= best_idx;
        vic_age <= best_cnt;
      end
    end
  end

endmodule

// File: rtl/age_victim_sel_chk.sv
module age_victim_sel_chk #(
  parameter int NUM_FRAMES = 8,
  parameter int CNT_W      = 4,
  parameter int IDX_W      = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             fill_vld,
  input logic [IDX_W-1:0] fill_idx,
  input logic             vic_req,
  input logic             vic_vld,
  input logic [IDX_W-1:0] vic_idx,
  input logic [CNT_W-1:0] vic_age,
  input logic [CNT_W-1:0] cnt_arr [NUM_FRAMES],
  input logic [NUM_FRAMES-1:0] used_vec
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] snap [NUM_FRAMES];
  logic             larger_seen;
  logic             lower_tie_seen;
  logic             age_matches;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_FRAMES; i++) snap[i] <= '0;
    end else if (vic_req) begin
      for (int i = 0; i < NUM_FRAMES; i++) snap[i] <= cnt_arr[i];
    end
  end

  always_comb begin
    larger_seen    = 1'b0;
    lower_tie_seen = 1'b0;
    age_matches    = 1'b0;
    for (int i = 0; i < NUM_FRAMES; i++) begin
      if (snap[i] > vic_age) larger_seen = 1'b1;
      if ((IDX_W'(i) < vic_idx) && (snap[i] == vic_age)) lower_tie_seen = 1'b1;
      if ((IDX_W'(i) == vic_idx) && (snap[i] == vic_age)) age_matches = 1'b1;
    end
  end

  a_r8_vld_after_req: assert property (@(posedge clk) disable iff (rst)
    vic_req |=> vic_vld);
  a_r8_vld_only_after_req: assert property (@(posedge clk) disable iff (rst)
    !vic_req |=> !vic_vld);
  a_r6_no_larger_frame: assert property (@(posedge clk) disable iff (rst)
    vic_vld |-> (!larger_seen && age_matches));
  a_r7_lowest_on_tie: assert property (@(posedge clk) disable iff (rst)
    vic_vld |-> !lower_tie_seen);
  a_r4_flags_dropped: assert property (@(posedge clk) disable iff (rst)
    (tick && !fill_vld) |=> (used_vec == '0));

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
      (tick && (cnt_arr[g] == CNT_MAX) && !(fill_vld && fill_idx == IDX_W'(g)))
      |=> ((cnt_arr[g] == CNT_MAX) || (cnt_arr[g] == '0)));
    a_r9_fill_restart: assert property (@(posedge clk) disable iff (rst)
      (fill_vld && fill_idx == IDX_W'(g)) |=> ((cnt_arr[g] == '0) && used_vec[g]));
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
      (!tick && !(fill_vld && fill_idx == IDX_W'(g))) |=> $stable(cnt_arr[g]));
  end

endmodule

bind age_victim_sel age_victim_sel_chk #(
  .NUM_FRAMES(NUM_FRAMES),
  .CNT_W     (CNT_W),
  .IDX_W     (IDX_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .fill_vld(fill_vld),
  .fill_idx(fill_idx),
  .vic_req (vic_req),
  .vic_vld (vic_vld),
  .vic_idx (vic_idx),
  .vic_age (vic_age),
  .cnt_arr (cnt_arr),
  .used_vec(used_vec)
);

// File: tb/age_victim_sel_bench.sv
`timescale 1ns/1ps
module age_victim_sel_bench;

  localparam int NF    = 8;
  localparam int CW    = 4;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          acc_vld;
  logic [IW-1:0] acc_idx;
  logic          fill_vld;
  logic [IW-1:0] fill_idx;
  logic          tick;
  logic          vic_req;
  logic          vic_vld;
  logic [IW-1:0] vic_idx;
  logic [CW-1:0] vic_age;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  age_victim_sel #(.NUM_FRAMES(NF), .CNT_W(CW)) u_age_victim_sel (
    .clk, .rst, .acc_vld, .acc_idx, .fill_vld, .fill_idx, .tick,
    .vic_req, .vic_vld, .vic_idx, .vic_age
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    acc_vld = 0; acc_idx = '0; fill_vld = 0; fill_idx = '0;
    tick = 0; vic_req = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  // One cycle of stimulus, applied at a falling edge and removed at the next.
  task automatic step(input bit a, input int ai, input bit f, input int fi, input bit t);
    acc_vld = a; acc_idx = IW'(ai); fill_vld = f; fill_idx = IW'(fi); tick = t;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 1);
  endtask

  task automatic query(input int exp_idx, input int exp_age, input bit with_tick,
                       input string tag);
    vic_req = 1; tick = with_tick;
    @(negedge clk);
    idle_inputs();
    check(vic_vld == 1'b1, "R8", "vic_vld after request", int'(vic_vld), 1);
    check(vic_idx == IW'(exp_idx), tag, "vic_idx", int'(vic_idx), exp_idx);
    check(vic_age == CW'(exp_age), tag, "vic_age", int'(vic_age), exp_age);
    @(negedge clk);
    check(vic_vld == 1'b0, "R8", "vic_vld one cycle later", int'(vic_vld), 0);
  endtask

  task automatic t_reset();
    do_reset();
    check(vic_vld == 1'b0, "R1", "vic_vld after reset", int'(vic_vld), 0);
    query(0, 0, 0, "R1");
  endtask

  task automatic t_age_and_use();
    do_reset();
    ticks(3);
    query(0, 3, 0, "R3");
    step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    ticks(1);
    query(2, 4, 0, "R2");
  endtask

  task automatic t_saturate();
    do_reset();
    ticks(20);
    query(0, 15, 0, "R3");
    for (int k = 0; k < 7; k++) step(1, k, 0, 0, 0);
    ticks(1);
    query(7, 15, 0, "R6");
  endtask

  task automatic t_same_cycle();
    do_reset();
    ticks(2);
    step(1, 0, 0, 0, 1);
    query(1, 3, 0, "R5");
    ticks(1);
    query(1, 4, 0, "R5");
  endtask

  task automatic t_flag_clear();
    do_reset();
    step(1, 0, 0, 0, 0);
    ticks(2);
    for (int k = 1; k < NF; k++) step(0, 0, 1, k, 0);
    query(0, 1, 0, "R4");
  endtask

  task automatic t_fill();
    do_reset();
    ticks(5);
    step(0, 0, 1, 0, 0);
    query(1, 5, 0, "R9");
    step(1, 1, 1, 1, 1);
    query(2, 6, 0, "R9");
    for (int k = 2; k < NF; k++) step(0, 0, 1, k, 0);
    ticks(1);
    query(0, 1, 0, "R9");
  endtask

  task automatic t_tie();
    do_reset();
    ticks(1);
    for (int k = 0; k < 3; k++) step(1, k, 0, 0, 0);
    ticks(1);
    query(3, 2, 0, "R7");
    step(0, 0, 1, 3, 0);
    query(4, 2, 0, "R7");
  endtask

  task automatic t_stale_request();
    do_reset();
    ticks(2);
    step(1, 0, 0, 0, 0);
    query(0, 2, 1, "R8");
    query(1, 3, 0, "R8");
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    t_reset();
    t_age_and_use();
    t_saturate();
    t_same_cycle();
    t_flag_clear();
    t_fill();
    t_tie();
    t_stale_request();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule